// File: doc/BRIEF.md
# In-Order Completion Queue with Branch Flush

This block keeps a circular record of in-flight instructions in program order. Each instruction gets a slot and a tag when it is dispatched. The execution units later report through the finish port that the instruction is done, and whether it raised an exception. From the oldest slot, the queue retires finished instructions strictly in order, at most three per cycle. An instruction never retires while an older one is still pending, and nothing retires past an instruction that has faulted.

When a branch is resolved as mispredicted, every slot younger than the branch is discarded. The next allocation then reuses the slot just after the branch. When the oldest entry has finished with a fault, the queue raises an exception-taken signal with that entry's tag, retires nothing, and empties itself on the next clock edge. A free count and a full flag tell the dispatch stage how much room is left. Allocation is all-or-nothing.

Top module: `completion_queue`

## Requirements
- R1: After reset the queue is empty: free count 16, full low, retire count 0, exception-taken low.
- R2: An allocation request of N entries (N = 1 to 3) is granted only when N does not exceed the free count. A granted request returns N consecutive tags, modulo 16, starting at the tail, in lane order. A refused request consumes no slots.
- R3: The queue holds at most 16 entries. The free count equals 16 minus the number of live entries, and full is high exactly when the free count is 0.
- R4: Entries retire in program order from the oldest live entry. The scan stops at the first entry that is unfinished or carries an exception, so no entry retires before every older entry has retired.
- R5: At most three entries retire in a cycle. Retire count is 0 to 3, and retire tag lane k holds the oldest tag plus k.
- R6: When the oldest live entry has finished with an exception, exception-taken is high, the exception tag equals that entry's tag, and the retire count is 0. From the next cycle the queue is empty (free count 16), and new tags continue from that entry's slot.
- R7: Entries older than a faulting entry still retire, and the faulting entry itself does not retire.
- R8: A mispredicted-branch report on a live tag discards all younger entries. From the next cycle the free count includes the released slots, and the next allocated tag is the branch tag plus 1.
- R9: A newly allocated entry starts unfinished and without an exception, whatever status its slot held before.
- R10: Tags wrap from 15 back to 0, and retirement continues in order across the wrap.
- R11: No allocation is granted in a cycle that flushes, whether through exception-taken or a mispredicted branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_cnt | input | 2 | Number of entries requested this cycle (0 to 3) |
| alloc_ok | output | 1 | Request granted, entries are written at the clock edge |
| alloc_tags | output | 12 | Three 4-bit tags for lanes 0 to 2, lane 0 in bits 3:0 |
| free_cnt | output | 5 | Free slots |
| full | output | 1 | No free slot |
| fin_valid | input | 1 | Finish report valid |
| fin_tag | input | 4 | Tag of the finished entry |
| fin_exc | input | 1 | Finished entry raised an exception |
| br_valid | input | 1 | Branch resolution valid |
| br_tag | input | 4 | Tag of the resolved branch |
| br_miss | input | 1 | Branch was mispredicted |
| ret_cnt | output | 2 | Entries retiring this cycle |
| ret_tags | output | 12 | Tags of retire lanes 0 to 2, lane 0 in bits 3:0 |
| exc_taken | output | 1 | Oldest entry has faulted, queue flushes at the edge |
| exc_tag | output | 4 | Tag of the oldest entry |

## Verification
Grant, tags, free count and full are combinational from the pointers. They are checked in the same cycle as the request, and the change a grant or flush causes is checked one edge later. A finish report is captured at an edge, and the retire outputs reflect it in the cycle that follows. The scoreboard monitor samples retire lanes every cycle just before the rising edge and compares them in order with tags the driver queued when it made those entries finishable. Exception-taken is checked in the cycle after the faulting entry becomes oldest, and the emptied queue one cycle after that.

// File: rtl/cq_pkg.sv
// Shared definitions for the completion queue.
// Assumes the queue depth is a power of two so tags wrap by truncation.
package cq_pkg;
    typedef struct packed {
        logic done;
        logic exc;
    } cq_stat_t;
endpackage

// File: rtl/cq_status.sv
// Per-slot finish/exception status storage.
// Allocation clears the slots it hands out; a finish report sets done and
// records the exception flag. Assumes fin_we is only asserted for live slots,
// and that a finish never targets a slot allocated in the same cycle.
module cq_status #(
    parameter int DEPTH   = 16,
    parameter int ALLOC_N = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(ALLOC_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_we,
    input  logic [IDX_W-1:0] alloc_base,
    input  logic [CNT_W-1:0] alloc_n,
    input  logic             fin_we,
    input  logic [IDX_W-1:0] fin_idx,
    input  logic             fin_exc,
    output logic [DEPTH-1:0] done_v,
    output logic [DEPTH-1:0] exc_v
);
    import cq_pkg::*;

    cq_stat_t         stat_q [DEPTH];
    logic [DEPTH-1:0] clr;

    // Build the mask of slots being handed out this cycle.
    always_comb begin
        clr = '0;
        for (int k = 0; k < ALLOC_N; k++) begin
            if (alloc_we && (CNT_W'(k) < alloc_n))
                clr[alloc_base + IDX_W'(k)] = 1'b1;
        end
    end

    // Update slot status on allocation and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stat_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr[i])
                    stat_q[i] <= '0;
                else if (fin_we && (fin_idx == IDX_W'(i)))
                    stat_q[i] <= '{done: 1'b1, exc: fin_exc};
            end
        end
    end

    // Flatten status for the scan logic.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            done_v[i] = stat_q[i].done;
            exc_v[i]  = stat_q[i].exc;
        end
    end

    // R9
    alloc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_we && alloc_n != '0) |=> !done_v[$past(alloc_base)]);

    // R4
    fin_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_we && !(alloc_we && alloc_n != '0)) |=> done_v[$past(fin_idx)]);
endmodule

// File: rtl/cq_scan.sv
// Retirement scan: walks from the oldest live slot and counts how many
// consecutive entries are finished without an exception, up to RET_N and
// up to an optional limit (used to keep the scan at or below a branch being
// flushed). Also flags a faulting oldest entry. Purely combinational.
module cq_scan #(
    parameter int DEPTH  = 16,
    parameter int RET_N  = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int PTR_W  = IDX_W + 1,
    localparam int RCNT_W = $clog2(RET_N + 1)
) (
    input  logic [IDX_W-1:0]       head_idx,
    input  logic [PTR_W-1:0]       occ,
    input  logic [DEPTH-1:0]       done_v,
    input  logic [DEPTH-1:0]       exc_v,
    input  logic                   lim_en,
    input  logic [PTR_W-1:0]       lim,
    output logic [RCNT_W-1:0]      ret_n,
    output logic [RET_N*IDX_W-1:0] ret_tags,
    output logic                   exc_head
);
    logic             run;
    logic [IDX_W-1:0] idx;

    // Count in-order retirable entries from the head.
    always_comb begin
        run   = 1'b1;
        ret_n = '0;
        idx   = head_idx;
        for (int k = 0; k < RET_N; k++) begin
            idx = head_idx + IDX_W'(k);
            if (run && (PTR_W'(k) < occ) && (!lim_en || (PTR_W'(k) < lim))
                && done_v[idx] && !exc_v[idx])
                ret_n = ret_n + RCNT_W'(1);
            else
                run = 1'b0;
        end
    end

    // Lane tags always follow the head.
    for (genvar g = 0; g < RET_N; g++) begin : g_lane
        assign ret_tags[g*IDX_W +: IDX_W] = head_idx + IDX_W'(g);
    end

    // Oldest live entry finished with an exception.
    assign exc_head = (occ != '0) && done_v[head_idx] && exc_v[head_idx];
endmodule

// File: rtl/completion_queue.sv
// In-order completion queue. Holds DEPTH in-flight entries between a head
// (oldest) and tail pointer, each carrying a wrap bit. Allocation is
// all-or-nothing. Retirement is in order, at most RET_N per cycle. A faulting
// oldest entry flushes the whole queue; a mispredicted branch discards
// entries younger than itself. Assumes DEPTH is a power of two and that
// finish and branch reports carry tags of dispatched entries (reports on
// dead tags are ignored).
module completion_queue #(
    parameter int DEPTH   = 16,
    parameter int ALLOC_N = 3,
    parameter int RET_N   = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int PTR_W  = IDX_W + 1,
    localparam int CNT_W  = $clog2(ALLOC_N + 1),
    localparam int RCNT_W = $clog2(RET_N + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         alloc_cnt,
    output logic                     alloc_ok,
    output logic [ALLOC_N*IDX_W-1:0] alloc_tags,
    output logic [PTR_W-1:0]         free_cnt,
    output logic                     full,
    input  logic                     fin_valid,
    input  logic [IDX_W-1:0]         fin_tag,
    input  logic                     fin_exc,
    input  logic                     br_valid,
    input  logic [IDX_W-1:0]         br_tag,
    input  logic                     br_miss,
    output logic [RCNT_W-1:0]        ret_cnt,
    output logic [RET_N*IDX_W-1:0]   ret_tags,
    output logic                     exc_taken,
    output logic [IDX_W-1:0]         exc_tag
);
    logic [PTR_W-1:0] head_q, tail_q, occ, fin_off, br_off;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             fin_live, br_flush;
    logic [DEPTH-1:0] done_v, exc_v;

    // Occupancy and offsets of reported tags from the head.
    always_comb begin
        head_idx = head_q[IDX_W-1:0];
        tail_idx = tail_q[IDX_W-1:0];
        occ      = tail_q - head_q;
        fin_off  = {1'b0, fin_tag - head_idx};
        br_off   = {1'b0, br_tag - head_idx};
        fin_live = fin_valid && (fin_off < occ);
        br_flush = br_valid && br_miss && (br_off < occ) && !exc_taken;
    end

    // Capacity and grant decision.
    assign free_cnt = PTR_W'(DEPTH) - occ;
    assign full     = (free_cnt == '0);
    assign alloc_ok = (alloc_cnt != '0) && (PTR_W'(alloc_cnt) <= free_cnt)
                      && !br_flush && !exc_taken;
    assign exc_tag  = head_idx;

    // Tags offered to each allocation lane.
    for (genvar g = 0; g < ALLOC_N; g++) begin : g_atag
        assign alloc_tags[g*IDX_W +: IDX_W] = tail_idx + IDX_W'(g);
    end

    cq_status #(.DEPTH(DEPTH), .ALLOC_N(ALLOC_N)) u_status (
        .clk(clk), .rst_n(rst_n),
        .alloc_we(alloc_ok), .alloc_base(tail_idx), .alloc_n(alloc_cnt),
        .fin_we(fin_live), .fin_idx(fin_tag), .fin_exc(fin_exc),
        .done_v(done_v), .exc_v(exc_v)
    );

    cq_scan #(.DEPTH(DEPTH), .RET_N(RET_N)) u_scan (
        .head_idx(head_idx), .occ(occ), .done_v(done_v), .exc_v(exc_v),
        .lim_en(br_flush), .lim(br_off + PTR_W'(1)),
        .ret_n(ret_cnt), .ret_tags(ret_tags), .exc_head(exc_taken)
    );

    // Advance head on retirement; move tail on flush or allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(ret_cnt);
            if (exc_taken)
                tail_q <= head_q;
            else if (br_flush)
                tail_q <= head_q + br_off + PTR_W'(1);
            else if (alloc_ok)
                tail_q <= tail_q + PTR_W'(alloc_cnt);
        end
    end

    // R3
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH));

    // R5
    ret_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(ret_cnt) <= occ);

    // R6
    exc_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> ret_cnt == '0);

    // R6
    exc_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> free_cnt == PTR_W'(DEPTH));

    // R8
    br_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_flush |=> occ <= $past(br_off) + PTR_W'(1));

    // R2
    alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |=> occ == $past(occ) + PTR_W'($past(alloc_cnt))
                            - PTR_W'($past(ret_cnt)));

    // R11
    flush_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken || br_flush) |-> !alloc_ok);
endmodule

// File: tb/tb_completion_queue.sv
module tb_completion_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alloc_cnt = '0;
    logic        alloc_ok, full, fin_valid = 1'b0, fin_exc = 1'b0;
    logic [11:0] alloc_tags, ret_tags;
    logic [4:0]  free_cnt;
    logic [3:0]  fin_tag = '0, br_tag = '0, exc_tag;
    logic        br_valid = 1'b0, br_miss = 1'b0, exc_taken;
    logic [1:0]  ret_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];
    bit done_run = 1'b0;

    always #5 clk = ~clk;

    completion_queue dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_cnt(alloc_cnt), .alloc_ok(alloc_ok), .alloc_tags(alloc_tags),
        .free_cnt(free_cnt), .full(full),
        .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
        .br_valid(br_valid), .br_tag(br_tag), .br_miss(br_miss),
        .ret_cnt(ret_cnt), .ret_tags(ret_tags),
        .exc_taken(exc_taken), .exc_tag(exc_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus: drive at the falling edge, settle before sampling.
    task automatic drive(input int ac, input bit fv, input int ft, input bit fe,
                         input bit bv, input int bt, input bit bm);
        @(negedge clk);
        alloc_cnt = 2'(ac);
        fin_valid = fv; fin_tag = 4'(ft); fin_exc = fe;
        br_valid = bv; br_tag = 4'(bt); br_miss = bm;
        #4;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fin(input int t, input bit e);
        drive(0, 1, t, e, 0, 0, 0);
    endtask

    // Allocate n entries and compare the granted tags with the expected start.
    task automatic alloc_chk(input int n, input int first, input string req);
        drive(n, 0, 0, 0, 0, 0, 0);
        chk(alloc_ok == 1'b1, req, int'(alloc_ok), 1);
        for (int k = 0; k < n; k++)
            chk(alloc_tags[k*4 +: 4] == 4'(first + k), req,
                int'(alloc_tags[k*4 +: 4]), (first + k) % 16);
    endtask

    // Scoreboard monitor: retire lanes are compared in order with queued tags.
    always @(negedge clk) begin
        if (rst_n) begin
            #4;
            for (int k = 0; k < int'(ret_cnt); k++) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R4", int'(ret_tags[k*4 +: 4]), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(ret_tags[k*4 +: 4] == 4'(e), "R4", int'(ret_tags[k*4 +: 4]), e);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done_run) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk(free_cnt == 5'd16, "R1", int'(free_cnt), 16);
        chk(full == 1'b0, "R1", int'(full), 0);
        chk(ret_cnt == 2'd0, "R1", int'(ret_cnt), 0);
        chk(exc_taken == 1'b0, "R1", int'(exc_taken), 0);

        alloc_chk(3, 0, "R2");
        alloc_chk(3, 3, "R2");
        idle();
        chk(free_cnt == 5'd10, "R3", int'(free_cnt), 10);

        // R4: head unfinished blocks younger finished entries
        fin(1, 0); fin(2, 0); idle();
        chk(ret_cnt == 2'd0, "R4", int'(ret_cnt), 0);
        fin(0, 0); exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
        idle();
        chk(ret_cnt == 2'd3, "R5", int'(ret_cnt), 3);

        // R5: four ready entries retire as 3 then 1
        alloc_chk(1, 6, "R2");
        fin(6, 0); fin(5, 0); fin(4, 0); fin(3, 0);
        for (int t = 3; t <= 6; t++) exp_q.push_back(t);
        idle();
        chk(ret_cnt == 2'd3, "R5", int'(ret_cnt), 3);
        idle();
        chk(ret_cnt == 2'd1, "R5", int'(ret_cnt), 1);
        idle();
        chk(free_cnt == 5'd16, "R3", int'(free_cnt), 16);

        // R7 / R6: fault in the middle, then at the head
        alloc_chk(3, 7, "R2");
        fin(8, 1); fin(9, 0); fin(7, 0); exp_q.push_back(7);
        idle();
        chk(ret_cnt == 2'd1, "R7", int'(ret_cnt), 1);
        chk(exc_taken == 1'b0, "R7", int'(exc_taken), 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        chk(exc_taken == 1'b1, "R6", int'(exc_taken), 1);
        chk(exc_tag == 4'd8, "R6", int'(exc_tag), 8);
        chk(ret_cnt == 2'd0, "R7", int'(ret_cnt), 0);
        chk(alloc_ok == 1'b0, "R11", int'(alloc_ok), 0);
        idle();
        chk(free_cnt == 5'd16, "R6", int'(free_cnt), 16);
        alloc_chk(2, 8, "R6");
        idle(); idle();
        chk(ret_cnt == 2'd0, "R9", int'(ret_cnt), 0);
        chk(exc_taken == 1'b0, "R9", int'(exc_taken), 0);

        // R8: mispredict on tag 11 discards 12..15
        alloc_chk(3, 10, "R2");
        alloc_chk(3, 13, "R2");
        idle();
        chk(free_cnt == 5'd8, "R3", int'(free_cnt), 8);
        drive(1, 0, 0, 0, 1, 11, 1);
        chk(alloc_ok == 1'b0, "R11", int'(alloc_ok), 0);
        idle();
        chk(free_cnt == 5'd12, "R8", int'(free_cnt), 12);
        alloc_chk(1, 12, "R8");
        fin(12, 0);
        fin(8, 0); exp_q.push_back(8);
        fin(9, 0); exp_q.push_back(9);
        fin(10, 0); exp_q.push_back(10);
        fin(11, 0); exp_q.push_back(11); exp_q.push_back(12);

        // R10: tags wrap past 15
        alloc_chk(3, 13, "R10");
        alloc_chk(2, 16, "R10");
        for (int t = 13; t <= 17; t++) begin
            fin(t % 16, 0); exp_q.push_back(t % 16);
        end
        idle(); idle(); idle();
        chk(free_cnt == 5'd16, "R10", int'(free_cnt), 16);
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);

        // R3 / R2: fill to capacity, oversize request refused
        for (int b = 0; b < 5; b++) alloc_chk(3, 2 + 3*b, "R2");
        drive(3, 0, 0, 0, 0, 0, 0);
        chk(alloc_ok == 1'b0, "R2", int'(alloc_ok), 0);
        idle();
        chk(free_cnt == 5'd1, "R2", int'(free_cnt), 1);
        alloc_chk(1, 17, "R2");
        idle();
        chk(full == 1'b1, "R3", int'(full), 1);
        chk(free_cnt == 5'd0, "R3", int'(free_cnt), 0);
        fin(2, 1);
        idle();
        chk(exc_taken == 1'b1, "R6", int'(exc_taken), 1);
        chk(exc_tag == 4'd2, "R6", int'(exc_tag), 2);
        idle();
        chk(free_cnt == 5'd16, "R6", int'(free_cnt), 16);
        chk(full == 1'b0, "R3", int'(full), 0);

        done_run = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule